// File: doc/BRIEF.md
# Sequential-Write RGB Input Lookup Table

This block is a colour lookup table for an input pixel path. It holds one 12-bit unsigned fraction (u0.12) per colour channel for each of 256 entries. Control logic programs it through a narrow sequential port. A write to the index port chooses the entry where programming begins. A write to the mask port chooses which channels may change. After that, plain data words are streamed one at a time. Each group of three words fills red, green and blue of one entry, and the entry index then moves forward by itself.

The pixel side presents three 8-bit components with a valid strobe. One cycle later the block returns the three 12-bit table values, each channel looked up in its own table. A bypass input skips the table and widens each component to 12 bits, so the table can be left unused when an earlier scaling stage is doing the conversion.

Top module: `rgb_lut_seq`

## Requirements
- R1: The table has 256 entries, each with separate 12-bit red, green and blue values. A lookup indexes the red table with pix_r, the green table with pix_g and the blue table with pix_b.
- R2: After reset, out_valid is low, the start index is 0, the next channel is red and the mask enables all channels. Mask bit 0 is red, bit 1 is green and bit 2 is blue.
- R3: Consecutive data writes (seq_wr high) store seq_data into red, then green, then blue of the current entry.
- R4: After the blue write, the index increases by one and the next write goes to red.
- R5: The index wraps from 255 to 0.
- R6: An index write (idx_wr high) loads idx_val as the current entry and returns the channel pointer to red. A data write in the same cycle as an index write is dropped.
- R7: A data write to a channel whose mask bit is 0 leaves the stored value unchanged but still moves the channel pointer on.
- R8: out_valid is high exactly one cycle after pix_valid was high. In that cycle out_r, out_g and out_b hold the table values of the sampled components.
- R9: When lut_bypass is high together with pix_valid, each output is the input component in bits 11:4 with bits 3:0 zero. The table is not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load start index |
| idx_val | input | 8 | Start index value |
| mask_wr | input | 1 | Load channel write mask |
| mask_val | input | 3 | Channel mask (bit0 red, bit1 green, bit2 blue) |
| seq_wr | input | 1 | Sequential data write strobe |
| seq_data | input | 12 | u0.12 data word |
| lut_bypass | input | 1 | 1 = pass pixels around the table |
| pix_valid | input | 1 | Pixel lookup request |
| pix_r | input | 8 | Red component |
| pix_g | input | 8 | Green component |
| pix_b | input | 8 | Blue component |
| out_valid | output | 1 | Lookup result valid |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |

## Verification
The bench uses the default parameters: an 8-bit index and 12-bit data, which gives the full 256-entry table. With that size it can program every entry in one run, write past entry 255 to check the wrap, and read the table with three different components in one lookup. This shows the channel tables are separate. Mid-triplet index loads, partial masks and bypass lookups are each run between table reads, so every effect is seen through the pixel outputs.

// File: rtl/rgb_lut_pkg.sv
package rgb_lut_pkg;
  localparam int NCH = 3;
  typedef enum logic [1:0] {
    CH_RED = 2'd0,
    CH_GRN = 2'd1,
    CH_BLU = 2'd2
  } chan_e;
endpackage

// File: rtl/rgb_lut_seqctl.sv
module rgb_lut_seqctl
  import rgb_lut_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             mask_wr,
  input  logic [NCH-1:0]   mask_val,
  input  logic             seq_wr,
  output logic [NCH-1:0]   bank_we,
  output logic [IDX_W-1:0] wr_addr
);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  chan_e            chan_q, chan_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [NCH-1:0]   mask_q, mask_d;
  logic             word_ok;

  assign word_ok = seq_wr && !idx_wr;

  always_comb begin
    idx_d  = idx_q;
    chan_d = chan_q;
    mask_d = mask_q;
    if (mask_wr) mask_d = mask_val;
    if (idx_wr) begin
      idx_d  = idx_val;
      chan_d = CH_RED;
    end else if (seq_wr) begin
      unique case (chan_q)
        CH_RED:  chan_d = CH_GRN;
        CH_GRN:  chan_d = CH_BLU;
        default: begin
          chan_d = CH_RED;
          idx_d  = idx_q + IDX_ONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      chan_q <= CH_RED;
      mask_q <= '1;
    end else begin
      idx_q  <= idx_d;
      chan_q <= chan_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    bank_we = '0;
    for (int c = 0; c < NCH; c++) begin
      bank_we[c] = word_ok && (chan_q == chan_e'(c)) && mask_q[c];
    end
  end

  assign wr_addr = idx_q;

  a_r3_chan_legal: assert property (@(posedge clk) disable iff (!rst_n)
    chan_q != chan_e'(2'd3));

  a_r3_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && chan_q == CH_BLU) |=> (idx_q == $past(idx_q) + IDX_ONE) && (chan_q == CH_RED));

  a_r6_idx_load: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (idx_q == $past(idx_val)) && (chan_q == CH_RED));

  a_r7_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (word_ok && !mask_q[chan_q]) |-> (bank_we == '0));
endmodule

// File: rtl/rgb_lut_bank.sv
module rgb_lut_bank #(
  parameter int IDX_W = 8,
  parameter int DAT_W = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DAT_W-1:0] wdata,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] raddr,
  output logic [DAT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rgb_lut_seq.sv
module rgb_lut_seq
  import rgb_lut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_wr,
  input  logic [IDX_W-1:0] idx_val,
  input  logic             mask_wr,
  input  logic [2:0]       mask_val,
  input  logic             seq_wr,
  input  logic [DAT_W-1:0] seq_data,
  input  logic             lut_bypass,
  input  logic             pix_valid,
  input  logic [IDX_W-1:0] pix_r,
  input  logic [IDX_W-1:0] pix_g,
  input  logic [IDX_W-1:0] pix_b,
  output logic             out_valid,
  output logic [DAT_W-1:0] out_r,
  output logic [DAT_W-1:0] out_g,
  output logic [DAT_W-1:0] out_b
);
  localparam int PAD = DAT_W - IDX_W;

  logic [NCH-1:0]            bank_we;
  logic [IDX_W-1:0]          wr_addr;
  logic [NCH-1:0][IDX_W-1:0] pix_in;
  logic [NCH-1:0][IDX_W-1:0] pix_q;
  logic [NCH-1:0][DAT_W-1:0] rd_val;
  logic [NCH-1:0][DAT_W-1:0] res;
  logic                      rd_en;
  logic                      byp_q;
  logic                      vld_d;

  assign pix_in = {pix_b, pix_g, pix_r};
  assign rd_en  = pix_valid && !lut_bypass;
  assign vld_d  = pix_valid;

  rgb_lut_seqctl #(.IDX_W(IDX_W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .idx_wr  (idx_wr),
    .idx_val (idx_val),
    .mask_wr (mask_wr),
    .mask_val(mask_val),
    .seq_wr  (seq_wr),
    .bank_we (bank_we),
    .wr_addr (wr_addr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rgb_lut_bank #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_bank (
      .clk  (clk),
      .we   (bank_we[c]),
      .waddr(wr_addr),
      .wdata(seq_data),
      .rd_en(rd_en),
      .raddr(pix_in[c]),
      .rdata(rd_val[c])
    );
    assign res[c] = byp_q ? {pix_q[c], {PAD{1'b0}}} : rd_val[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      byp_q     <= 1'b0;
      pix_q     <= '0;
    end else begin
      out_valid <= vld_d;
      if (pix_valid) begin
        byp_q <= lut_bypass;
        pix_q <= pix_in;
      end
    end
  end

  assign out_r = res[0];
  assign out_g = res[1];
  assign out_b = res[2];

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  a_r9_bypass_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && lut_bypass) |=> (out_r[PAD-1:0] == '0) && (out_g[PAD-1:0] == '0));
endmodule

// File: tb/rgb_lut_seq_bench.sv
module rgb_lut_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        idx_wr = 1'b0;
  logic [7:0]  idx_val = '0;
  logic        mask_wr = 1'b0;
  logic [2:0]  mask_val = '0;
  logic        seq_wr = 1'b0;
  logic [11:0] seq_data = '0;
  logic        lut_bypass = 1'b0;
  logic        pix_valid = 1'b0;
  logic [7:0]  pix_r = '0, pix_g = '0, pix_b = '0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int ref_t [3][256];
  int m_idx = 0;
  int m_ch = 0;
  int m_mask = 7;

  always #10 clk = ~clk;

  rgb_lut_seq u_rgb_lut_seq (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
    .mask_wr(mask_wr), .mask_val(mask_val), .seq_wr(seq_wr), .seq_data(seq_data),
    .lut_bypass(lut_bypass), .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g),
    .pix_b(pix_b), .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_word(int d);
    if (m_mask[m_ch]) ref_t[m_ch][m_idx] = d & 12'hFFF;
    if (m_ch == 2) begin
      m_ch = 0;
      m_idx = (m_idx + 1) % 256;
    end else m_ch++;
  endtask

  task automatic put_word(int d);
    @(negedge clk);
    seq_wr = 1'b1; seq_data = 12'(d);
    @(negedge clk);
    seq_wr = 1'b0;
    model_word(d);
  endtask

  task automatic put_idx(int i);
    @(negedge clk);
    idx_wr = 1'b1; idx_val = 8'(i);
    @(negedge clk);
    idx_wr = 1'b0;
    m_idx = i; m_ch = 0;
  endtask

  task automatic put_mask(int m);
    @(negedge clk);
    mask_wr = 1'b1; mask_val = 3'(m);
    @(negedge clk);
    mask_wr = 1'b0;
    m_mask = m;
  endtask

  task automatic look(int r, int g, int b, string tag);
    @(negedge clk);
    pix_valid = 1'b1; pix_r = 8'(r); pix_g = 8'(g); pix_b = 8'(b);
    @(negedge clk);
    pix_valid = 1'b0;
    chk({tag, " R8 valid"}, int'(out_valid), 1);
    if (lut_bypass) begin
      chk({tag, " R9 red"},   int'(out_r), r << 4);
      chk({tag, " R9 green"}, int'(out_g), g << 4);
      chk({tag, " R9 blue"},  int'(out_b), b << 4);
    end else begin
      chk({tag, " red"},   int'(out_r), ref_t[0][r]);
      chk({tag, " green"}, int'(out_g), ref_t[1][g]);
      chk({tag, " blue"},  int'(out_b), ref_t[2][b]);
    end
    @(negedge clk);
    chk({tag, " R8 single valid"}, int'(out_valid), 0);
  endtask

  // R2: reset state, default index 0 and full mask
  task automatic t_reset;
    @(negedge clk);
    chk("R2 out_valid after reset", int'(out_valid), 0);
    put_word(12'h111); put_word(12'h222); put_word(12'h333);
    look(0, 0, 0, "R2 default start");
  endtask

  // R1 R3 R4: fill whole table, read with mixed components
  task automatic t_fill;
    put_idx(0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++)
        put_word((i * 37 + c * 1000 + 5) & 12'hFFF);
    look(1, 2, 3, "R1 R3 mixed");
    look(255, 128, 7, "R4 far entries");
    look(200, 200, 200, "R3 same entry");
  endtask

  // R5: writes beyond entry 255 land in entry 0
  task automatic t_wrap;
    put_idx(255);
    put_word(12'hA01); put_word(12'hA02); put_word(12'hA03);
    put_word(12'hB01); put_word(12'hB02); put_word(12'hB03);
    look(255, 255, 255, "R5 last entry");
    look(0, 0, 0, "R5 wrapped");
  endtask

  // R7: masked channels keep value, pointer still advances
  task automatic t_mask;
    put_mask(3'b010);
    put_idx(10);
    put_word(12'hC01); put_word(12'hC02); put_word(12'hC03);
    put_word(12'hD01); put_word(12'hD02); put_word(12'hD03);
    put_mask(3'b111);
    look(10, 10, 10, "R7 green only");
    look(11, 11, 11, "R7 pointer advanced");
  endtask

  // R6: index load mid-triplet and simultaneous data drop
  task automatic t_idx;
    put_idx(20);
    put_word(12'hE01);
    put_idx(30);
    put_word(12'hE11); put_word(12'hE12); put_word(12'hE13);
    look(20, 20, 20, "R6 partial entry");
    look(30, 30, 30, "R6 restart red");
    @(negedge clk);
    idx_wr = 1'b1; idx_val = 8'd40; seq_wr = 1'b1; seq_data = 12'hF00;
    @(negedge clk);
    idx_wr = 1'b0; seq_wr = 1'b0;
    m_idx = 40; m_ch = 0;
    put_word(12'hF01); put_word(12'hF02); put_word(12'hF03);
    look(40, 40, 40, "R6 dropped word");
    look(39, 39, 39, "R6 neighbour intact");
  endtask

  // R9: bypass path
  task automatic t_bypass;
    lut_bypass = 1'b1;
    look(8'h5A, 8'hFF, 8'h00, "R9 bypass a");
    look(8'h01, 8'h80, 8'hC3, "R9 bypass b");
    lut_bypass = 1'b0;
    look(8'h5A, 8'hFF, 8'h00, "R9 back to table");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_wrap();
    t_mask();
    t_idx();
    t_bypass();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule